// File: doc/BRIEF.md
# Serial Unlock Key Detector

This block guards entry into a low-voltage programming mode. While an active-low hold pin is driven low, it watches a two-wire serial link (a serial clock and a serial data line) and shifts the data into a 32-bit register, least significant bit first. When 32 bits have been taken, one more serial clock arms the comparison. If the shifted word equals the fixed unlock key and the mode-enable configuration bit is 1, the mode output goes high.

The mode output stays high for as long as the hold pin stays low. Releasing the pin drops the output and clears all partial progress. A wrong key, or a key that arrives while the configuration bit is 0, sends the block into a locked state. In that state it ignores every further serial clock until the hold pin is released and driven low again. The serial clock and data are brought into the system clock domain through two-flop synchronisers. Data is taken on each detected rising edge of the serial clock.

Top module: `unlock_key_detect`

## Requirements
- R1: After system reset, `mode_o` is 0.
- R2: The key is 32'h4D434850, sent least significant bit first, one bit per serial clock rising edge. With `lv_en_i`=1, the 33rd rising edge raises `mode_o` within 3 system clock cycles. The same word sent most significant bit first does not raise `mode_o`.
- R3: After only the 32 key clocks, without the 33rd, `mode_o` stays 0.
- R4: `mode_o` goes to 0 on the first system clock edge that samples `hold_n`=1. Releasing the pin also clears the shift register and the bit count, so a new attempt after releasing mid-key starts from bit zero.
- R5: If `lv_en_i` is 0 at the 33rd serial clock, the correct key does not raise `mode_o`.
- R6: Any 32-bit word other than the key leaves `mode_o` at 0 on the 33rd clock. Later serial clocks, including a correct key, are then ignored until `hold_n` is released and driven low again.
- R7: While `mode_o` is 1 and `hold_n` stays low, further serial clocks leave `mode_o` at 1.
- R8: Serial clocks that arrive while `hold_n` is 1 have no effect. A key sent then does not raise `mode_o`, and a later attempt with `hold_n` low needs all 32 bits plus the arming clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| hold_n | input | 1 | Active-low hold/enable pin, synchronous to `clk` |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdat_i | input | 1 | Serial data, sampled at rising `sclk_i` |
| lv_en_i | input | 1 | Low-voltage entry configuration bit |
| mode_o | output | 1 | Programming mode active |

## Verification
The assertions assume that `hold_n` is already synchronous to the system clock. They also assume that each serial clock level lasts at least two system clock cycles, so that every rising edge is seen once, and that `sdat_i` is stable across the synchroniser delay. The bench drives every input on the falling system clock edge and holds each serial clock phase for four system cycles. It changes data only while the serial clock is low. Random words are either the key or values guaranteed to differ from it, and the configuration bit is drawn at random for each attempt.

// File: rtl/unlock_key_detect.sv
module unlock_key_detect #(
  parameter int KEY_W = 32,
  parameter logic [KEY_W-1:0] KEY = 32'h4D434850
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_n,
  input  logic sclk_i,
  input  logic sdat_i,
  input  logic lv_en_i,
  output logic mode_o
);
  localparam int CW = $clog2(KEY_W + 1);
  localparam logic [CW-1:0] FULL = CW'(KEY_W);

  logic [2:0]       sclk_s;
  logic [1:0]       sdat_s;
  logic [KEY_W-1:0] shift_q;
  logic [CW-1:0]    cnt_q;
  logic             dead_q, mode_q;
  logic             rise, take;

  assign rise   = sclk_s[1] & ~sclk_s[2];
  assign take   = rise & ~hold_n & ~dead_q & ~mode_q;
  assign mode_o = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_s <= '0;
      sdat_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      sdat_s <= {sdat_s[0], sdat_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      dead_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else if (take) begin
      if (cnt_q != FULL) begin
        shift_q <= {sdat_s[1], shift_q[KEY_W-1:1]};
        cnt_q   <= cnt_q + 1'b1;
      end else if (lv_en_i && shift_q == KEY) begin
        mode_q <= 1'b1;
      end else begin
        dead_q <= 1'b1;
      end
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_arm_after_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> $past(cnt_q) == FULL);
  p_release_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_n) |-> !mode_q && cnt_q == '0);
  p_locked_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dead_q && mode_q));
  p_mode_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q) |-> $past(hold_n));
  p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_q && !hold_n) |=> $stable(cnt_q));
endmodule

// File: tb/unlock_key_detect_tb.sv
module unlock_key_detect_tb_top;
  localparam logic [31:0] KEY = 32'h4D434850;

  logic clk = 1'b0, rst_n = 1'b0, hold_n = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, lv_en = 1'b1;
  logic mode;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  unlock_key_detect dut_i (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .sclk_i(sclk),
    .sdat_i(sdat), .lv_en_i(lv_en), .mode_o(mode)
  );

  function automatic logic exp_mode(logic [31:0] w, logic en);
    return en && (w == KEY);
  endfunction

  function automatic logic [31:0] rev32(logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = w[31-i];
    return r;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic b);
    sdat = b;
    wait_clk(1);
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
    wait_clk(4);
  endtask

  task automatic send_word(logic [31:0] w);
    for (int i = 0; i < 32; i++) pulse(w[i]);
  endtask

  task automatic check(string req, logic exp);
    checks++;
    if (mode !== exp) begin
      failures++;
      $display("FAIL %s mode_o actual=%b expected=%b", req, mode, exp);
    end
  endtask

  task automatic release_pin();
    hold_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic attempt(logic [31:0] w);
    hold_n = 1'b0;
    wait_clk(2);
    send_word(w);
    pulse($urandom_range(0, 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wait_clk(4);
    check("R1", 1'b0);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1", 1'b0);

    hold_n = 1'b0;
    wait_clk(2);
    send_word(KEY);
    check("R3", 1'b0);
    pulse(1'b0);
    check("R2", 1'b1);
    for (int i = 0; i < 5; i++) pulse($urandom_range(0, 1));
    check("R7", 1'b1);
    hold_n = 1'b1;
    wait_clk(1);
    check("R4", 1'b0);
    wait_clk(1);

    hold_n = 1'b0;
    wait_clk(2);
    for (int i = 0; i < 10; i++) pulse($urandom_range(0, 1));
    release_pin();
    attempt(KEY);
    check("R4", 1'b1);
    release_pin();

    lv_en = 1'b0;
    attempt(KEY);
    check("R5", 1'b0);
    lv_en = 1'b1;
    release_pin();

    attempt(KEY ^ (32'd1 << $urandom_range(0, 31)));
    check("R6", 1'b0);
    send_word(KEY);
    pulse(1'b0);
    check("R6", 1'b0);
    release_pin();
    attempt(KEY);
    check("R6", 1'b1);
    release_pin();

    attempt(rev32(KEY));
    check("R2", 1'b0);
    release_pin();

    send_word(KEY);
    pulse(1'b0);
    check("R8", 1'b0);
    hold_n = 1'b0;
    wait_clk(2);
    pulse(1'b0);
    check("R8", 1'b0);
    release_pin();
    attempt(KEY);
    check("R8", 1'b1);
    release_pin();

    for (int n = 0; n < 24; n++) begin
      logic [31:0] w;
      logic en;
      w = ($urandom_range(0, 2) == 0) ? KEY : $urandom();
      if (w != KEY && $urandom_range(0, 1) == 1) w = KEY ^ (32'd1 << $urandom_range(0, 31));
      en = $urandom_range(0, 3) != 0;
      lv_en = en;
      attempt(w);
      check(w == KEY ? "R2" : "R6", exp_mode(w, en));
      release_pin();
      check("R4", 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule